// File: doc/BRIEF.md
# Two-Byte Serial Register Port

This block is a serial slave through which a host programs and reads back a small bank of configuration registers. Every transaction is a fixed pair of bytes framed by an active-low select: first a control byte that the host always writes, carrying a read flag and a register address, then a data byte. On a write, the block captures the data byte into the addressed register. On a read, the block shifts the addressed register's contents back to the host.

The serial pins are oversampled in the block's own clock domain. Select, serial clock and serial input each pass through a synchronizer, and edges of the serial clock are detected there. The port therefore needs no clock of its own and stays usable whatever the rest of the chip is doing. The full register bank is also presented in parallel for the logic it configures.

A mode input chooses between two wirings. With separate lines, the output driver is on for the whole time select is low. With one shared data line, the driver turns on only for the data byte of a read, and whatever the shared line carries during that byte is ignored. The output driver is released at once whenever select is high.

Top module: `spi_regport`

## Requirements
- R1: After the asynchronous reset, every register in the parallel bank reads zero and the output enable is low.
- R2: While `cs_n` is high, `miso_oe` is low, and `sclk` and `mosi` activity changes no register.
- R3: Serial input is sampled on rising `sclk` edges while select is low, most significant bit first. In the control byte, bit 7 is the read flag (1 = read), bits 4:0 are the register address, and bits 6:5 are ignored. On a write, the 16th rising edge stores the data byte into `reg_bank[addr*8 +: 8]`.
- R4: On a read, the addressed register is driven on `miso` most significant bit first. Each bit is launched after a falling `sclk` edge, so rising edges 9 to 16 sample bits 7 to 0. A read leaves every register unchanged.
- R5: If select rises before the 16th rising edge, the partial frame is discarded and no register changes.
- R6: Clock edges after the 16th rising edge are ignored until select goes high. A new frame starts only after select goes high and then low again.
- R7: With `three_wire` = 0, `miso_oe` is high throughout the frame while select is low.
- R8: With `three_wire` = 1, `miso_oe` is high only during the data byte of a read. During a write, or during the control byte, the driver stays off.
- R9: A rising `sclk` edge that arrives together with select going high is not counted. If that edge would have been the 16th, the write does not happen.
- R10: Select, serial clock and serial input are synchronized to `clk`. Each phase of `sclk` must last at least four `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1 = shared data line, 0 = separate lines |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host (in shared mode, the line's input buffer) |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output driver enable for the data pin |
| reg_bank | output | NUM_REGS*DATA_W | All registers, register n at bits n*DATA_W upward |

## Verification
Two events can land in the same oversampled cycle: the last serial clock rise that completes a write, and the deassertion of select. The bench provokes this by raising `cs_n` and `sclk` at the same instant on the 16th bit, which makes the synchronized versions of both change together. It then judges the outcome at the parallel bank, where the addressed register must keep its old value. An ordinary write to the same register follows, to show that this register does accept writes.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   // frame progress within one select window
   typedef enum logic [1:0] {
      PH_CTRL = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } phase_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
   parameter int NUM_REGS = 32,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] bank
);

   localparam int SPAN = 1 << ADDR_W;

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
               regs[i] <= wr_data;
         end
         assign bank[i*DATA_W +: DATA_W] = regs[i];
      end

      if (NUM_REGS == SPAN) begin : g_full_map
         assign rd_data = regs[rd_addr];
      end else begin : g_sparse_map
         // addresses beyond the bank read as zero
         always_comb begin
            rd_data = '0;
            for (int k = 0; k < NUM_REGS; k++)
               if (rd_addr == ADDR_W'(k)) rd_data = regs[k];
         end
      end
   endgenerate

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
   import spi_regport_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              rd_flag,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              tx_bit,
   output phase_t            phase
);

   localparam int SH_W  = max2(CTRL_W, DATA_W);
   localparam int RX_W  = SH_W - 1;
   localparam int CNT_W = $clog2(SH_W);
   localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   logic [RX_W-1:0]   rx;
   logic [CNT_W-1:0]  cnt;
   logic              loaded;
   logic [DATA_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CTRL;
         cnt     <= '0;
         rx      <= '0;
         addr    <= '0;
         rd_flag <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         loaded  <= 1'b0;
         tx_sh   <= '0;
         tx_bit  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (!sel) begin
            // select inactive: discard any partial frame
            phase  <= PH_CTRL;
            cnt    <= '0;
            loaded <= 1'b0;
            tx_bit <= 1'b0;
         end else begin
            unique case (phase)
               PH_CTRL: begin
                  if (rise) begin
                     rx <= {rx[RX_W-2:0], sdi};
                     if (cnt == CTRL_LAST) begin
                        rd_flag <= rx[CTRL_W-2];
                        addr    <= {rx[ADDR_W-2:0], sdi};
                        phase   <= PH_DATA;
                        cnt     <= '0;
                        loaded  <= 1'b0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               PH_DATA: begin
                  if (rise) begin
                     if (!rd_flag) rx <= {rx[RX_W-2:0], sdi};
                     if (cnt == DATA_LAST) begin
                        phase <= PH_DONE;
                        if (!rd_flag) begin
                           wr_en   <= 1'b1;
                           wr_data <= {rx[DATA_W-2:0], sdi};
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (fall && rd_flag) begin
                     if (!loaded) begin
                        tx_bit <= rd_data[DATA_W-1];
                        tx_sh  <= rd_data << 1;
                        loaded <= 1'b1;
                     end else begin
                        tx_bit <= tx_sh[DATA_W-1];
                        tx_sh  <= tx_sh << 1;
                     end
                  end
               end
               default: begin
                  // frame complete: wait for select to rise
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS    = 32,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int CTRL_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       three_wire,
   input  logic                       cs_n,
   input  logic                       sclk,
   input  logic                       mosi,
   output logic                       miso,
   output logic                       miso_oe,
   output logic [NUM_REGS*DATA_W-1:0] reg_bank
);

   localparam logic [2:0] SYNC_RST = 3'b100;  // {cs_n, sclk, mosi}

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (ADDR_W >= 2 && ADDR_W <= CTRL_W - 1) else $error("ADDR_W must fit below the read flag");
      assert (NUM_REGS >= 1 && NUM_REGS <= (1 << ADDR_W)) else $error("NUM_REGS exceeds address space");
      assert (DATA_W >= 3 && CTRL_W >= 3) else $error("byte widths too small");
   end

   logic [2:0] pin_s;
   logic       cs_s, sclk_s, mosi_s, sclk_d;
   logic       sclk_rise, sclk_fall, sel;

   spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({cs_n, sclk, mosi}),
      .q    (pin_s)
   );

   assign cs_s   = pin_s[2];
   assign sclk_s = pin_s[1];
   assign mosi_s = pin_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign sel       = ~cs_s;

   logic [ADDR_W-1:0] addr;
   logic              rd_flag, wr_en, tx_bit;
   logic [DATA_W-1:0] wr_data, rd_data;
   phase_t            phase;
   logic              data_phase, drive_req;

   spi_regport_frame #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .rise   (sclk_rise),
      .fall   (sclk_fall),
      .sdi    (mosi_s),
      .rd_data(rd_data),
      .addr   (addr),
      .rd_flag(rd_flag),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .tx_bit (tx_bit),
      .phase  (phase)
   );

   spi_regport_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(addr),
      .wr_data(wr_data),
      .rd_addr(addr),
      .rd_data(rd_data),
      .bank   (reg_bank)
   );

   assign data_phase = (phase == PH_DATA);
   // shared line: drive only while returning read data
   assign drive_req  = three_wire ? (data_phase & rd_flag) : 1'b1;
   // raw select releases the pin without synchronizer delay
   assign miso_oe    = ~cs_n & sel & drive_req;
   assign miso       = tx_bit;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
   parameter int BANK_W = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              three_wire,
   input logic              miso_oe,
   input logic              wr_en,
   input logic              rd_flag,
   input logic              data_phase,
   input logic [BANK_W-1:0] reg_bank
);

   p_hiz_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !miso_oe);

   p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_wr_not_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_flag);

   p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(reg_bank));

   p_shared_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (three_wire && miso_oe) |-> (data_phase && rd_flag));

endmodule

bind spi_regport spi_regport_chk #(.BANK_W(NUM_REGS*DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .three_wire(three_wire),
   .miso_oe   (miso_oe),
   .wr_en     (wr_en),
   .rd_flag   (rd_flag),
   .data_phase(data_phase),
   .reg_bank  (reg_bank)
);

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;

   localparam int NREG = 32;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic three_wire = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic mosi = 1'b0;
   logic miso, miso_oe;
   logic [NREG*8-1:0] reg_bank;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] model [NREG];

   always #2 clk = ~clk;

   spi_regport u_spi_regport (
      .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .cs_n(cs_n),
      .sclk(sclk), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
      .reg_bank(reg_bank)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic logic [NREG*8-1:0] model_flat();
      logic [NREG*8-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   task automatic check_bank(input string tag);
      logic [NREG*8-1:0] e;
      e = model_flat();
      check(reg_bank === e, $sformatf("%s bank actual=%h expected=%h", tag, reg_bank, e));
   endtask

   // stream is sent MSB first; returns read byte and count of enable mismatches
   task automatic xfer(input logic [23:0] stream, input int nbits, input bit coincide,
                       output logic [7:0] rdata, output int oe_bad);
      logic exp_oe;
      rdata = '0;
      oe_bad = 0;
      cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0;
         mosi = stream[23-i];
         tick(HALF);
         exp_oe = three_wire ? (i >= 8 && i < 16 && stream[23]) : 1'b1;
         if (miso_oe !== exp_oe) oe_bad++;
         if (i >= 8 && i < 16) rdata[15-i] = miso;
         sclk = 1'b1;
         if (coincide && i == nbits - 1) cs_n = 1'b1;
         tick(HALF);
      end
      sclk = 1'b0;
      tick(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      tick(2*HALF);
   endtask

   function automatic logic [7:0] wval(input int a, input int tw);
      return 8'(a*29 + tw*101 + 7);
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] rd;
      logic [7:0] ctrl;
      int bad;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      tick(5);
      // R1: reset state
      check(reg_bank === '0, $sformatf("R1 reset bank actual=%h expected=0", reg_bank));
      check(miso_oe === 1'b0, $sformatf("R1 reset oe actual=%b expected=0", miso_oe));
      rst_n = 1'b1;
      tick(5);

      for (int tw = 0; tw < 2; tw++) begin
         three_wire = tw[0];
         tick(4);
         // R3: write every register; bits 6:5 of control carry junk
         for (int a = 0; a < NREG; a++) begin
            ctrl = {1'b0, 2'(a), 5'(a)};
            xfer({ctrl, wval(a, tw), 8'h00}, 16, 1'b0, rd, bad);
            model[a] = wval(a, tw);
            check_bank($sformatf("R3 write a=%0d tw=%0d", a, tw));
            check(bad == 0, $sformatf("%s write oe a=%0d mismatches actual=%0d expected=0",
                                      tw ? "R8" : "R7", a, bad));
         end
         // R4: read every register back
         for (int a = 0; a < NREG; a++) begin
            ctrl = {1'b1, 2'(~a), 5'(a)};
            xfer({ctrl, 8'h5A, 8'h00}, 16, 1'b0, rd, bad);
            check(rd === model[a], $sformatf("R4 read a=%0d tw=%0d actual=%h expected=%h",
                                             a, tw, rd, model[a]));
            check(bad == 0, $sformatf("%s read oe a=%0d mismatches actual=%0d expected=0",
                                      tw ? "R8" : "R7", a, bad));
         end
         check_bank($sformatf("R4 reads leave bank tw=%0d", tw));
      end

      three_wire = 1'b0;
      tick(4);
      // R5: aborted frames
      xfer({8'h03, 8'hEE, 8'h00}, 12, 1'b0, rd, bad);
      check_bank("R5 abort after 12 bits");
      xfer({8'h03, 8'hEE, 8'h00}, 15, 1'b0, rd, bad);
      check_bank("R5 abort after 15 bits");

      // R9: 16th rise coincides with select deassertion
      xfer({8'h04, 8'hC3, 8'h00}, 16, 1'b1, rd, bad);
      check_bank("R9 coincident edge discarded");
      xfer({8'h04, 8'hC3, 8'h00}, 16, 1'b0, rd, bad);
      model[4] = 8'hC3;
      check_bank("R9 follow-up write accepted");

      // R6: extra clocks after the data byte are ignored
      xfer({8'h05, 8'h96, 8'hFF}, 24, 1'b0, rd, bad);
      model[5] = 8'h96;
      check_bank("R6 trailing clocks after write");
      xfer({8'h85, 8'h00, 8'h00}, 24, 1'b0, rd, bad);
      check(rd === 8'h96, $sformatf("R6 read with trailing clocks actual=%h expected=96", rd));
      check(bad == 0, $sformatf("R7 oe over 24 bits mismatches actual=%0d expected=0", bad));

      // R8: shared-line write keeps driver off, trailing bits too
      three_wire = 1'b1;
      tick(4);
      xfer({8'h06, 8'h3C, 8'hAA}, 24, 1'b0, rd, bad);
      model[6] = 8'h3C;
      check(bad == 0, $sformatf("R8 shared write oe mismatches actual=%0d expected=0", bad));
      check_bank("R8 shared write stored");
      three_wire = 1'b0;

      // R2: activity with select high changes nothing, pin released
      cs_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 16; i++) begin
         sclk = 1'b0;
         mosi = (i % 3) == 0;
         tick(HALF);
         if (miso_oe !== 1'b0) bad++;
         sclk = 1'b1;
         tick(HALF);
      end
      sclk = 1'b0;
      tick(2*HALF);
      check(bad == 0, $sformatf("R2 oe with select high actual=%0d expected=0", bad));
      check_bank("R2 no write with select high");
      check(miso_oe === 1'b0, $sformatf("R2 idle oe actual=%b expected=0", miso_oe));

      // R10: a frame right after select-high activity still works
      xfer({8'h87, 8'h00, 8'h00}, 16, 1'b0, rd, bad);
      check(rd === model[7], $sformatf("R10 read after idle actual=%h expected=%h", rd, model[7]));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule